// File: doc/BRIEF.md
# Debug Watchpoint and Breakpoint Unit

This block watches three streams of a processor core and flags software events without slowing the core. The streams are the instruction fetch effective address, the load/store effective address and the load/store data value. A bank of eight programmable comparators holds one reference value each. Four comparators are wired to the fetch address, two to the load/store address and two to the load/store data. Each comparator tests its stream value against its reference with one of four relations.

Six watchpoints combine the comparator hits through a selection mask, in either an any-of or an all-of mode. A watchpoint output is raised in the cycle after the matching stream beat. Each watchpoint drives its own event counter. Software loads a count, and the matching breakpoint output pulses when the counter reaches zero. The counter then rests until it is loaded again. All configuration goes through a simple write-only register port. Every stream accepts a beat on every cycle, so the unit never adds a stall.

Top module: `dbg_watch_unit`

## Requirements
- R1: After reset, `wp_out` and `bp_out` are all zero, every comparator is disabled, every watchpoint mask is empty and every event counter holds zero.
- R2: Comparators 0 to 3 test `ifetch_ea` only when `ifetch_vld` is high. Comparators 4 and 5 test `ls_ea` only when `ls_avld` is high. Comparators 6 and 7 test `ls_data` only when `ls_dvld` is high. A stream whose strobe is low produces no hit, whatever its value.
- R3: The relation field of a comparator control word selects the test. Bits [2:1] = 00 means stream equals reference, 01 means not equal, 10 means stream less than reference, and 11 means stream greater than reference. The less-than and greater-than tests compare unsigned 32-bit values.
- R4: A comparator whose enable bit (control bit 0) is clear never hits.
- R5: A watchpoint control word holds a comparator mask in bits [7:0] and a mode in bit 8. With bit 8 clear, the watchpoint fires if any selected comparator hits. With bit 8 set, it fires only if every selected comparator hits. A watchpoint with an empty mask never fires.
- R6: `wp_out[k]` is high in exactly the clock cycle after the stream beat that fires watchpoint k. Back-to-back beats give back-to-back outputs, with no stall.
- R7: Writing a count N to a watchpoint's count register makes `bp_out[k]` pulse for one cycle, together with `wp_out[k]`, on the Nth following event. Later events raise no breakpoint until the next load. A count of 0 never raises one.
- R8: When a count load and an event of the same watchpoint fall in the same cycle, the load wins and that event is not counted.
- R9: Register map on `cfg_addr`: 0..7 comparator reference values, 8..15 comparator controls, 16..21 watchpoint controls, 24..29 watchpoint counts (16 bits). A write to any other address changes nothing.
- R10: `bp_out[k]` is never high while `wp_out[k]` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 5 | Configuration register address |
| cfg_wdata | input | 32 | Configuration write data |
| ifetch_vld | input | 1 | Instruction fetch address valid |
| ifetch_ea | input | 32 | Instruction fetch effective address |
| ls_avld | input | 1 | Load/store address valid |
| ls_ea | input | 32 | Load/store effective address |
| ls_dvld | input | 1 | Load/store data valid |
| ls_data | input | 32 | Load/store data value |
| wp_out | output | 6 | Registered watchpoint event flags |
| bp_out | output | 6 | Registered breakpoint pulses |

## Verification
A count load from the register port and a watchpoint event on the same counter can land in the same cycle. The bench provokes this by issuing the count write in the very cycle that a matching fetch address is presented. It judges the result by the event that follows. The breakpoint must appear only after the full reloaded count, which proves that the concurrent event was dropped. It must not appear one event early.

// File: rtl/dwu_pkg.sv
package dwu_pkg;
  typedef enum logic [1:0] {
    REL_EQ = 2'b00,
    REL_NE = 2'b01,
    REL_LT = 2'b10,
    REL_GT = 2'b11
  } rel_e;

  localparam int CFG_AW       = 5;
  localparam int CFG_DW       = 32;
  localparam int MAP_CMP_VAL  = 0;
  localparam int MAP_CMP_CTL  = 8;
  localparam int MAP_WP_CTL   = 16;
  localparam int MAP_WP_CNT   = 24;
endpackage

// File: rtl/dwu_comparator.sv
module dwu_comparator
  import dwu_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         val_we,
  input  logic [W-1:0] val_data,
  input  logic         ctl_we,
  input  logic [2:0]   ctl_data,
  input  logic         strobe,
  input  logic [W-1:0] operand,
  output logic         hit
);
  logic [W-1:0] ref_q;
  logic         en_q;
  rel_e         rel_q;
  logic         rel_true;

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_q <= '0;
      en_q  <= 1'b0;
      rel_q <= REL_EQ;
    end else begin
      if (val_we) ref_q <= val_data;
      if (ctl_we) begin
        en_q  <= ctl_data[0];
        rel_q <= rel_e'(ctl_data[2:1]);
      end
    end
  end

  always_comb begin
    unique case (rel_q)
      REL_EQ:  rel_true = (operand == ref_q);
      REL_NE:  rel_true = (operand != ref_q);
      REL_LT:  rel_true = (operand <  ref_q);
      default: rel_true = (operand >  ref_q);
    endcase
  end

  assign hit = en_q & strobe & rel_true;
endmodule

// File: rtl/dwu_wp_combine.sv
module dwu_wp_combine #(
  parameter int N_CMP = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_we,
  input  logic [N_CMP:0]   ctl_data,
  input  logic [N_CMP-1:0] hits,
  output logic             match
);
  logic [N_CMP-1:0] mask_q;
  logic             all_mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q     <= '0;
      all_mode_q <= 1'b0;
    end else if (ctl_we) begin
      mask_q     <= ctl_data[N_CMP-1:0];
      all_mode_q <= ctl_data[N_CMP];
    end
  end

  logic any_sel, all_sel;
  assign any_sel = |(hits & mask_q);
  assign all_sel = &(hits | ~mask_q);
  assign match   = (|mask_q) & (all_mode_q ? all_sel : any_sel);
endmodule

// File: rtl/dwu_event_counter.sv
module dwu_event_counter #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             event_i,
  output logic             fire_q
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      fire_q <= 1'b0;
    end else begin
      fire_q <= 1'b0;
      if (load) begin
        cnt_q <= load_val;
      end else if (event_i && cnt_q != '0) begin
        cnt_q  <= cnt_q - 1'b1;
        fire_q <= (cnt_q == CNT_W'(1));
      end
    end
  end
endmodule

// File: rtl/dbg_watch_unit.sv
module dbg_watch_unit
  import dwu_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int N_IA   = 4,
  parameter int N_LA   = 2,
  parameter int N_LD   = 2,
  parameter int N_WP   = 6,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [4:0]        cfg_addr,
  input  logic [31:0]       cfg_wdata,
  input  logic              ifetch_vld,
  input  logic [ADDR_W-1:0] ifetch_ea,
  input  logic              ls_avld,
  input  logic [ADDR_W-1:0] ls_ea,
  input  logic              ls_dvld,
  input  logic [DATA_W-1:0] ls_data,
  output logic [N_WP-1:0]   wp_out,
  output logic [N_WP-1:0]   bp_out
);
  localparam int N_CMP = N_IA + N_LA + N_LD;

  logic [N_CMP-1:0] hits;
  logic [N_WP-1:0]  wp_next;

  for (genvar i = 0; i < N_CMP; i++) begin : g_cmp
    logic val_we, ctl_we;
    assign val_we = cfg_we && (cfg_addr == CFG_AW'(MAP_CMP_VAL + i));
    assign ctl_we = cfg_we && (cfg_addr == CFG_AW'(MAP_CMP_CTL + i));
    if (i < N_IA) begin : g_ia
      dwu_comparator #(.W(ADDR_W)) u_cmp (
        .clk(clk), .rst(rst),
        .val_we(val_we), .val_data(cfg_wdata[ADDR_W-1:0]),
        .ctl_we(ctl_we), .ctl_data(cfg_wdata[2:0]),
        .strobe(ifetch_vld), .operand(ifetch_ea), .hit(hits[i]));
    end else if (i < N_IA + N_LA) begin : g_la
      dwu_comparator #(.W(ADDR_W)) u_cmp (
        .clk(clk), .rst(rst),
        .val_we(val_we), .val_data(cfg_wdata[ADDR_W-1:0]),
        .ctl_we(ctl_we), .ctl_data(cfg_wdata[2:0]),
        .strobe(ls_avld), .operand(ls_ea), .hit(hits[i]));
    end else begin : g_ld
      dwu_comparator #(.W(DATA_W)) u_cmp (
        .clk(clk), .rst(rst),
        .val_we(val_we), .val_data(cfg_wdata[DATA_W-1:0]),
        .ctl_we(ctl_we), .ctl_data(cfg_wdata[2:0]),
        .strobe(ls_dvld), .operand(ls_data), .hit(hits[i]));
    end
  end

  for (genvar k = 0; k < N_WP; k++) begin : g_wp
    logic ctl_we, cnt_we;
    assign ctl_we = cfg_we && (cfg_addr == CFG_AW'(MAP_WP_CTL + k));
    assign cnt_we = cfg_we && (cfg_addr == CFG_AW'(MAP_WP_CNT + k));

    dwu_wp_combine #(.N_CMP(N_CMP)) u_comb (
      .clk(clk), .rst(rst),
      .ctl_we(ctl_we), .ctl_data(cfg_wdata[N_CMP:0]),
      .hits(hits), .match(wp_next[k]));

    dwu_event_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst(rst),
      .load(cnt_we), .load_val(cfg_wdata[CNT_W-1:0]),
      .event_i(wp_next[k]), .fire_q(bp_out[k]));
  end

  always_ff @(posedge clk) begin
    if (rst) wp_out <= '0;
    else     wp_out <= wp_next;
  end
endmodule

// File: rtl/dwu_checker.sv
module dwu_checker #(
  parameter int N_WP = 6
) (
  input logic            clk,
  input logic            rst,
  input logic            ifetch_vld,
  input logic            ls_avld,
  input logic            ls_dvld,
  input logic [N_WP-1:0] wp_out,
  input logic [N_WP-1:0] bp_out
);
  logic rst_d = 1'b0;

  always_ff @(posedge clk) begin
    rst_d <= rst;
    if (!rst && rst_d) begin
      AST_RESET_QUIET: assert (wp_out == '0 && bp_out == '0); // R1
    end
  end

  AST_IDLE_NO_WP: assert property (@(posedge clk) disable iff (rst)
    (!ifetch_vld && !ls_avld && !ls_dvld) |=> (wp_out == '0)); // R2

  AST_BP_NEEDS_WP: assert property (@(posedge clk) disable iff (rst)
    ((bp_out & ~wp_out) == '0)); // R10

  AST_BP_SINGLE: assert property (@(posedge clk) disable iff (rst)
    (bp_out != '0) |=> ((bp_out & $past(bp_out)) == '0)); // R7
endmodule

bind dbg_watch_unit dwu_checker #(.N_WP(N_WP)) u_chk (
  .clk(clk), .rst(rst),
  .ifetch_vld(ifetch_vld), .ls_avld(ls_avld), .ls_dvld(ls_dvld),
  .wp_out(wp_out), .bp_out(bp_out));

// File: tb/dbg_watch_unit_tb.sv
module dbg_watch_unit_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [4:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic        ifetch_vld = 1'b0;
  logic [31:0] ifetch_ea = '0;
  logic        ls_avld = 1'b0;
  logic [31:0] ls_ea = '0;
  logic        ls_dvld = 1'b0;
  logic [31:0] ls_data = '0;
  logic [5:0]  wp_out, bp_out;

  dbg_watch_unit u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .ifetch_vld(ifetch_vld), .ifetch_ea(ifetch_ea),
    .ls_avld(ls_avld), .ls_ea(ls_ea), .ls_dvld(ls_dvld), .ls_data(ls_data),
    .wp_out(wp_out), .bp_out(bp_out));

  always #4 clk = ~clk;

  typedef struct {
    int         due;
    logic [5:0] wp;
    logic [5:0] bp;
    string      tag;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done = 1'b0;

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  // monitor: pops items that are due this cycle and compares them
  always @(posedge clk) begin
    #2;
    cyc++;
    while (q.size() > 0 && q[0].due == cyc) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (wp_out !== e.wp || bp_out !== e.bp) begin
        n_bad++;
        $display("FAIL %s: wp=%h bp=%h expected wp=%h bp=%h", e.tag, wp_out, bp_out, e.wp, e.bp);
      end
    end
  end

  // driver: one cycle of stimulus and the outputs it must produce
  task automatic drive(input logic we, input logic [4:0] a, input logic [31:0] wd,
                       input logic iv, input logic [31:0] iea,
                       input logic av, input logic [31:0] aea,
                       input logic dv, input logic [31:0] dd,
                       input logic [5:0] ew, input logic [5:0] eb, input string tag);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = wd;
    ifetch_vld = iv; ifetch_ea = iea;
    ls_avld = av; ls_ea = aea; ls_dvld = dv; ls_data = dd;
    q.push_back('{cyc + 1, ew, eb, tag});
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    drive(1'b1, a, d, 1'b0, 0, 1'b0, 0, 1'b0, 0, 6'h00, 6'h00, "R9 cfg write quiet");
  endtask

  task automatic fetch(input logic [31:0] ea, input logic [5:0] ew, input logic [5:0] eb, input string tag);
    drive(1'b0, 5'd0, 0, 1'b1, ea, 1'b0, 0, 1'b0, 0, ew, eb, tag);
  endtask

  task automatic lsbeat(input logic av, input logic [31:0] aea, input logic dv, input logic [31:0] dd,
                        input logic [5:0] ew, input string tag);
    drive(1'b0, 5'd0, 0, 1'b0, 0, av, aea, dv, dd, ew, 6'h00, tag);
  endtask

  initial begin
    #(8 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    n_chk++;
    if (wp_out !== 6'h00 || bp_out !== 6'h00) begin
      n_bad++;
      $display("FAIL R1 reset: wp=%h bp=%h expected 00 00", wp_out, bp_out);
    end
    fetch(32'h0, 6'h00, 6'h00, "R1 comparators off after reset");

    // eq comparator 0 on fetch stream, watchpoint 0 any-of
    wr(5'd0, 32'h0000_1000); wr(5'd8, 32'h1); wr(5'd16, 32'h001);
    fetch(32'h0000_1000, 6'h01, 6'h00, "R2 fetch eq hit");
    fetch(32'h0000_1004, 6'h00, 6'h00, "R3 eq miss");
    drive(1'b0, 5'd0, 0, 1'b0, 32'h1000, 1'b0, 0, 1'b0, 0, 6'h00, 6'h00, "R2 fetch strobe low");
    lsbeat(1'b1, 32'h1000, 1'b0, 0, 6'h00, "R2 ls addr not seen by fetch comparator");

    // lt / gt, unsigned
    wr(5'd1, 32'h8000_0000); wr(5'd9, 32'h5); wr(5'd17, 32'h002);
    fetch(32'h7FFF_FFFF, 6'h02, 6'h00, "R3 lt hit");
    fetch(32'h8000_0000, 6'h00, 6'h00, "R3 lt equal miss");
    fetch(32'hFFFF_FFFF, 6'h00, 6'h00, "R3 lt unsigned miss");
    wr(5'd9, 32'h7);
    fetch(32'hFFFF_FFFF, 6'h02, 6'h00, "R3 gt unsigned hit");
    fetch(32'h8000_0000, 6'h00, 6'h00, "R3 gt equal miss");

    // ne, then disable
    wr(5'd2, 32'h5); wr(5'd10, 32'h3); wr(5'd18, 32'h004);
    fetch(32'h5, 6'h00, 6'h00, "R3 ne equal miss");
    fetch(32'h6, 6'h04, 6'h00, "R3 ne hit");
    wr(5'd10, 32'h2);
    fetch(32'h6, 6'h00, 6'h00, "R4 disabled comparator");

    // load/store comparators, all-of and any-of
    wr(5'd4, 32'h2000); wr(5'd12, 32'h1);
    wr(5'd6, 32'hDEAD_BEEF); wr(5'd14, 32'h1);
    wr(5'd20, 32'h150); wr(5'd21, 32'h050);
    lsbeat(1'b1, 32'h2000, 1'b1, 32'h0, 6'h20, "R5 any-of one hit");
    lsbeat(1'b1, 32'h2000, 1'b1, 32'hDEAD_BEEF, 6'h30, "R5 all-of both hit");
    lsbeat(1'b0, 32'h2000, 1'b1, 32'hDEAD_BEEF, 6'h20, "R5 all-of data only");
    lsbeat(1'b1, 32'h2000, 1'b0, 32'hDEAD_BEEF, 6'h20, "R2 data strobe low");
    lsbeat(1'b0, 32'h2000, 1'b0, 32'hDEAD_BEEF, 6'h00, "R2 both strobes low");
    wr(5'd19, 32'h100);
    fetch(32'h1000, 6'h01, 6'h00, "R5 empty mask all-of");

    // back to back
    fetch(32'h1000, 6'h01, 6'h00, "R6 b2b 1");
    fetch(32'h1000, 6'h01, 6'h00, "R6 b2b 2");
    fetch(32'h1004, 6'h00, 6'h00, "R6 b2b gap");
    fetch(32'h1000, 6'h01, 6'h00, "R6 b2b 3");

    // event counting; breakpoint always coincides with watchpoint (R10)
    wr(5'd24, 32'd3);
    fetch(32'h1000, 6'h01, 6'h00, "R7 count 3 ev1");
    fetch(32'h1000, 6'h01, 6'h00, "R7 count 3 ev2");
    fetch(32'h1000, 6'h01, 6'h01, "R7 R10 count 3 ev3 fires");
    fetch(32'h1000, 6'h01, 6'h00, "R7 held after fire");
    wr(5'd24, 32'd1);
    fetch(32'h1000, 6'h01, 6'h01, "R7 count 1 fires");
    wr(5'd24, 32'd0);
    fetch(32'h1000, 6'h01, 6'h00, "R7 count 0 never");

    // load and event in the same cycle
    wr(5'd24, 32'd2);
    drive(1'b1, 5'd24, 32'd2, 1'b1, 32'h1000, 1'b0, 0, 1'b0, 0, 6'h01, 6'h00, "R8 load with event");
    fetch(32'h1000, 6'h01, 6'h00, "R8 first counted event");
    fetch(32'h1000, 6'h01, 6'h01, "R8 second counted event fires");

    // unmapped addresses
    wr(5'd22, 32'hFFFF_FFFF); wr(5'd23, 32'hFFFF_FFFF);
    wr(5'd30, 32'hFFFF_FFFF); wr(5'd31, 32'hFFFF_FFFF);
    fetch(32'h1000, 6'h01, 6'h00, "R9 unmapped write no effect hit");
    fetch(32'h1004, 6'h00, 6'h00, "R9 unmapped write no effect miss");
    lsbeat(1'b1, 32'h2000, 1'b1, 32'hDEAD_BEEF, 6'h30, "R9 ls config intact");

    drive(1'b0, 5'd0, 0, 1'b0, 0, 1'b0, 0, 1'b0, 0, 6'h00, 6'h00, "R2 idle");
    repeat (3) @(negedge clk);
    n_chk++;
    if (q.size() != 0) begin
      n_bad++;
      $display("FAIL R6 scoreboard: %0d items left expected 0", q.size());
    end
    done = 1'b1;
    finish_run();
  end
endmodule